// File: doc/BRIEF.md
# Periodic DRAM Refresh Scheduler

This block sits on the controller side of a synchronous DRAM interface. Its job is to make sure the whole array is refreshed within the 64 ms retention window. It does this by spreading one auto-refresh over each fixed slice of that window. A free-running interval timer marks each slice and adds one refresh to an owed count. While anything is owed, the block raises a request to the command arbiter. If every bank is idle, the request carries an auto-refresh. If any bank is still open, it carries a precharge-all instead.

Once the arbiter grants an auto-refresh, the block holds off all further traffic for the refresh cycle time. It needs no precharge afterwards, because the device closes all banks by itself. If the arbiter is slow, refreshes can be postponed up to a bounded count. When it frees up, the owed refreshes are issued back to back until the count is zero again. The memory keeps its own row pointer, so no address leaves this block.

With a 100 MHz clock and 8192 rows, the defaults are an interval of 780 cycles and a refresh cycle time of 8 cycles.

Top module: `refresh_sched`

## Requirements
- R1: After reset is released, the first refresh request appears exactly INTERVAL_CYC+1 clock edges later. Each further INTERVAL_CYC cycles adds one owed refresh.
- R2: During and right after reset, cmd_req and busy are low and cmd_code is 2'b00 (no command).
- R3: cmd_code carries 2'b10 (auto-refresh) only while cmd_req is high and banks_idle is high.
- R4: While requesting with banks_idle low, cmd_code is 2'b01 (precharge-all). A grant of that command leaves cmd_req high and the owed count unchanged.
- R5: After an auto-refresh is granted, cmd_req stays low for exactly TRFC_CYC cycles.
- R6: busy rises together with the first request. It falls exactly TRFC_CYC cycles after the last granted auto-refresh once nothing more is owed.
- R7: When the refresh cycle time ends with nothing owed, no command follows: cmd_req is low and cmd_code is 2'b00.
- R8: At most MAX_DEBT refreshes are held as owed. Intervals that end while the count is full add nothing.
- R9: Owed refreshes are issued back to back, one grant every TRFC_CYC+1 cycles while grant stays high, and busy stays high between them.
- R10: A request stays up until it is granted. grant has no effect while cmd_req is low. cmd_code is non-zero exactly when cmd_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | High when every bank is precharged |
| grant | input | 1 | Arbiter accepts the presented command this edge |
| cmd_req | output | 1 | Command request to the arbiter |
| cmd_code | output | 2 | 00 none, 01 precharge-all, 10 auto-refresh |
| busy | output | 1 | Refresh work pending or refresh cycle time running |

## Verification
The assertions are checked on every cycle. They cover how the command code matches the request and the bank state, the blocking of the bus right after an auto-refresh grant, that a granted precharge keeps the request alive, and the bound on the owed count.

Some behaviour can only be shown by the bench's scenarios, which count edges from reset:
- the exact cycle of the first request;
- the number of refreshes that drain after each length of postponement, including the saturated cases;
- the spacing of back-to-back grants;
- the cycle in which busy drops.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } rs_state_t;

  localparam logic [1:0] CMD_NONE    = 2'b00;
  localparam logic [1:0] CMD_PRE_ALL = 2'b01;
  localparam logic [1:0] CMD_AUTOREF = 2'b10;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add,
  input  logic          take,
  output logic [DW-1:0] owed,
  output logic          any_owed
);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  logic [DW-1:0] owed_q;

  assign owed     = owed_q;
  assign any_owed = (owed_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else begin
      unique case ({add, take})
        2'b10:   if (owed_q != FULL) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/refresh_hold_timer.sv
module refresh_hold_timer #(
  parameter int TRFC_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int TW = (TRFC_CYC > 1) ? $clog2(TRFC_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TRFC_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q <= '0;
    end else if (run && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 780,
  parameter int TRFC_CYC     = 8,
  parameter int MAX_DEBT     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       banks_idle,
  input  logic       grant,
  output logic       cmd_req,
  output logic [1:0] cmd_code,
  output logic       busy
);
  localparam int DW = $clog2(MAX_DEBT + 1);

  rs_state_t     state_q, state_d;
  logic          tick;
  logic          any_owed;
  logic [DW-1:0] debt_q;
  logic          ref_taken;
  logic          hold_done;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  refresh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk      (clk),
    .rst      (rst),
    .add      (tick),
    .take     (ref_taken),
    .owed     (debt_q),
    .any_owed (any_owed)
  );

  refresh_hold_timer #(.TRFC_CYC(TRFC_CYC)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (ref_taken),
    .run   (state_q == ST_HOLD),
    .done  (hold_done)
  );

  assign cmd_req   = (state_q == ST_REQ);
  assign busy      = (state_q != ST_IDLE);
  assign ref_taken = cmd_req && grant && banks_idle;

  always_comb begin
    if (!cmd_req)        cmd_code = CMD_NONE;
    else if (banks_idle) cmd_code = CMD_AUTOREF;
    else                 cmd_code = CMD_PRE_ALL;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (any_owed)  state_d = ST_REQ;
      ST_REQ:  if (ref_taken) state_d = ST_HOLD;
      ST_HOLD: if (hold_done) state_d = any_owed ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          banks_idle,
  input logic          grant,
  input logic          cmd_req,
  input logic [1:0]    cmd_code,
  input logic          busy,
  input logic [DW-1:0] owed
);
  assert_autoref_needs_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 2'b10) |-> (cmd_req && banks_idle));

  assert_pre_keeps_request_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && grant && !banks_idle) |=> (cmd_req && $stable(owed)));

  assert_bus_blocked_after_ref_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && grant && banks_idle) |=> (!cmd_req && busy));

  assert_busy_covers_req_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> busy);

  assert_debt_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    owed <= DW'(MAX_DEBT));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !grant) |=> cmd_req);

  assert_code_matches_req_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_code != 2'b00) == cmd_req);
endmodule

bind refresh_sched refresh_sched_checker #(.MAX_DEBT(MAX_DEBT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .banks_idle (banks_idle),
  .grant      (grant),
  .cmd_req    (cmd_req),
  .cmd_code   (cmd_code),
  .busy       (busy),
  .owed       (debt_q)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int INTERVAL = 20;
  localparam int TRFC     = 4;
  localparam int MAXD     = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       banks_idle = 1'b1;
  logic       grant = 1'b0;
  logic       cmd_req;
  logic [1:0] cmd_code;
  logic       busy;

  int tests = 0;
  int fails = 0;
  int wd = 0;

  always #2 clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .MAX_DEBT(MAXD)) uut (
    .clk(clk), .rst(rst), .banks_idle(banks_idle), .grant(grant),
    .cmd_req(cmd_req), .cmd_code(cmd_code), .busy(busy)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    grant = 1'b0;
    banks_idle = 1'b1;
    repeat (3) step();
    check(!cmd_req && !busy && cmd_code == 2'b00, "R2 reset outputs",
          {cmd_req, busy, cmd_code}, 0);
    rst = 1'b0;
  endtask

  initial begin
    int edge_n;
    int first_req;
    int last_acc;
    int nref;
    int gap_bad;

    // R1/R2/R5/R6/R7/R10: grant held high from reset onward
    do_reset();
    check(!cmd_req && !busy && cmd_code == 2'b00, "R2 after release", {cmd_req, busy}, 0);
    grant = 1'b1;
    first_req = -1;
    for (int c = 1; c <= INTERVAL + 5 && first_req < 0; c++) begin
      step();
      if (cmd_req) first_req = c;
    end
    check(first_req == INTERVAL + 1, "R1 first request edge", first_req, INTERVAL + 1);
    check(busy, "R6 busy with request", busy, 1);
    check(cmd_code == 2'b10, "R3 autoref code when idle", cmd_code, 2);
    // accepted at next edge; then low for TRFC samples
    nref = 0;
    for (int k = 0; k < TRFC; k++) begin
      step();
      if (!cmd_req && busy) nref++;
    end
    check(nref == TRFC, "R5 hold cycles", nref, TRFC);
    step();
    check(!busy, "R6 busy drop after hold", busy, 0);
    check(!cmd_req && cmd_code == 2'b00, "R7 no command after refresh", cmd_code, 0);
    repeat (5) step();
    check(!cmd_req, "R10 grant ignored while idle", cmd_req, 0);

    // R4: precharge first while a bank is open
    do_reset();
    for (int c = 1; c <= INTERVAL + 1; c++) step();
    banks_idle = 1'b0;
    grant = 1'b1;
    #0;
    check(cmd_req && cmd_code == 2'b01, "R4 precharge code", cmd_code, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      check(cmd_req && cmd_code == 2'b01, "R4 request kept after precharge grant", cmd_code, 1);
    end
    banks_idle = 1'b1;
    #0;
    check(cmd_code == 2'b10, "R3 autoref once idle", cmd_code, 2);
    nref = 0;
    for (int k = 0; k < 3 * (TRFC + 1); k++) begin
      if (cmd_req && cmd_code == 2'b10) nref++;
      step();
    end
    check(nref == 1, "R4 owed count unchanged by precharge", nref, 1);
    check(!busy, "R6 idle after single refresh", busy, 0);

    // R8/R9/R6/R7: sweep of postponement depth
    for (int n = 1; n <= MAXD + 2; n++) begin
      do_reset();
      for (int c = 1; c <= n * INTERVAL + 2; c++) step();
      check(busy && cmd_req, "R10 request held without grant", cmd_req, 1);
      grant = 1'b1;
      nref = 0;
      gap_bad = 0;
      last_acc = -1;
      edge_n = 0;
      while (busy && edge_n < 200) begin
        if (cmd_req && cmd_code == 2'b10) begin
          if (last_acc >= 0 && edge_n - last_acc != TRFC + 1) gap_bad++;
          last_acc = edge_n;
          nref++;
        end
        step();
        edge_n++;
      end
      check(nref == ((n < MAXD) ? n : MAXD), "R8 drained refresh count", nref,
            (n < MAXD) ? n : MAXD);
      check(gap_bad == 0, "R9 back-to-back spacing", gap_bad, 0);
      check(edge_n - last_acc == TRFC + 1, "R6 busy end after last hold",
            edge_n - last_acc, TRFC + 1);
      check(!cmd_req && cmd_code == 2'b00, "R7 quiet after drain", cmd_code, 0);
      grant = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule